// File: doc/BRIEF.md
# Floating-Point Exception Control Register

This block is the 32-bit control and status word of a floating-point/SIMD unit. It has two jobs. It holds the unit-wide enable. It also records why the most recent synchronous floating-point exception was taken.

Software writes the word through a one-cycle write strobe and reads it back combinationally. The execution pipeline pulses a capture strobe when an exception is taken, and gives the cause with that pulse:
- whether the instruction encoding was allocated;
- whether the cause was an arithmetic instruction issued with a nonzero vector stride or length;
- which exception classes were raised;
- the current trap enables;
- the flush-to-zero controls.

A separate access strobe reports whether an FP register or status access must be treated as undefined. It is undefined whenever the enable bit is clear.

The pending/valid bit is held by a two-state machine:
- **CLEAR**: no valid cause is recorded.
- **HELD**: a cause from an allocated encoding is recorded.

It has three transitions:
- **CLEAR→HELD**: a capture from an allocated encoding.
- **HELD→CLEAR**: a capture from an unallocated encoding, or a software write with bit 29 at 0.
- **hold**: every other cycle.

Top module: `fpx_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` reads 32'h0000_0700. The enable bit, bit 29, bit 26 and all six flag bits are 0.
- R2: Bits 31, 28, 27, 25:11 and 6:5 always read 0, and bits 10:8 always read 1. Software writes to them have no effect.
- R3: Bit 30 takes the value of `sw_wdata[30]` on every software write, including a write in the same cycle as a capture. `fp_undef` equals `fp_access` while bit 30 is 0, and is 0 while bit 30 is 1.
- R4: A capture from an allocated encoding that is not a vector cause sets bit 29 and bit 26 to 1. It loads each implemented flag with raised AND trap-enable. The flag bits are: invalid operation bit 0 (`cap_raised[0]`), divide-by-zero bit 1 ([1]), overflow bit 2 ([2]), underflow bit 3 ([3]), inexact bit 4 ([4]) and input denormal bit 7 ([5]).
- R5: A capture from an allocated encoding with a vector cause sets bit 29 to 1, sets bit 26 to 0 and clears all flags.
- R6: A capture from an unallocated encoding clears bit 29, bit 26 and all flags.
- R7: The input-denormal flag is captured as 1 only if `flush_zero` is 1 and `half_flush` is 0.
- R8: Bit 26 ignores software writes and changes only on a capture.
- R9: A software write with bit 29 at 0 clears bit 29. A software write with bit 29 at 1 leaves bit 29 unchanged. Implemented flag bits take the written value.
- R10: A class whose bit in `TRAP_IMPL` is 0 reads 0 in its flag bit and ignores both software writes and captures.
- R11: When a capture and a software write fall in the same cycle, the capture decides bit 29, bit 26 and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Current register value |
| cap_valid | input | 1 | Exception capture strobe |
| cap_allocated | input | 1 | Exception came from an allocated encoding |
| cap_vector | input | 1 | Cause is a nonzero vector stride/length |
| cap_raised | input | 6 | Exception classes raised (ID,IX,UF,OF,DZ,IO from bit 5 down) |
| trap_en | input | 6 | Trap enables, same order as `cap_raised` |
| flush_zero | input | 1 | Flush-to-zero active |
| half_flush | input | 1 | Denormal came from a half-precision flush |
| fp_access | input | 1 | An FP register/status access is attempted |
| fp_undef | output | 1 | That access is undefined |

## Verification
A state machine stuck in HELD, or one that drops out of HELD, shows up as a wrong bit 29 on the read port in the cycle after the capture or write that should have moved it. A stale trapped-fault-valid bit or a stale flag register shows the same way, one cycle after the event. The sweep captures every combination of raised classes, trap enables and flush controls. After each capture it compares the whole word on the next falling edge. It uses two trap-implementation masks, so a wrong gate or a wrong bit mapping shows within one capture.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int REG_W   = 32;
    localparam int NUM_CLS = 6;
    localparam int ID_IDX  = NUM_CLS - 1;
    localparam int EN_BIT  = 30;
    localparam int DEX_BIT = 29;
    localparam int TFV_BIT = 26;
    localparam logic [REG_W-1:0] FIXED_ONES = 32'h0000_0700;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_HELD  = 1'b1
    } exc_state_e;

    // register bit of each exception class; the denormal class sits apart
    function automatic int cls_pos(input int idx);
        return (idx == ID_IDX) ? 7 : idx;
    endfunction
endpackage

// File: rtl/fpx_cause.sv
module fpx_cause
    import fpx_pkg::*;
(
    input  logic               cap_allocated,
    input  logic               cap_vector,
    input  logic [NUM_CLS-1:0] cap_raised,
    input  logic [NUM_CLS-1:0] trap_en,
    input  logic               flush_zero,
    input  logic               half_flush,
    output logic [NUM_CLS-1:0] cap_flags
);
    logic [NUM_CLS-1:0] eligible;

    always_comb begin
        eligible = cap_raised & trap_en;
        if (!(flush_zero && !half_flush)) begin
            eligible[ID_IDX] = 1'b0;
        end
        cap_flags = (cap_allocated && !cap_vector) ? eligible : '0;
    end
endmodule

// File: rtl/fpx_exc_fsm.sv
module fpx_exc_fsm
    import fpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_valid,
    input  logic cap_allocated,
    input  logic cap_vector,
    input  logic sw_wr,
    input  logic sw_dex,
    output logic dex,
    output logic tfv
);
    exc_state_e state_q, state_d;
    logic       tfv_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (cap_valid && cap_allocated) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (cap_valid) begin
                    if (!cap_allocated) state_d = ST_CLEAR;
                end else if (sw_wr && !sw_dex) begin
                    state_d = ST_CLEAR;
                end
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tfv_q <= 1'b0;
        else if (cap_valid) tfv_q <= cap_allocated && !cap_vector;
    end

    always_comb begin
        dex = (state_q == ST_HELD);
        tfv = tfv_q;
    end

    // R8
    tfv_sw_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> $stable(tfv));
    // R6
    unalloc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_allocated) |=> (!dex && !tfv));
    // R9
    dex_set_by_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_valid && !dex) |=> !dex);
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank
    import fpx_pkg::*;
#(
    parameter logic [NUM_CLS-1:0] TRAP_IMPL = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_valid,
    input  logic [NUM_CLS-1:0] cap_flags,
    input  logic               sw_wr,
    input  logic [NUM_CLS-1:0] sw_flags,
    output logic [NUM_CLS-1:0] flags
);
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
        if (TRAP_IMPL[g]) begin : g_impl
            logic flag_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         flag_q <= 1'b0;
                else if (cap_valid) flag_q <= cap_flags[g];
                else if (sw_wr)     flag_q <= sw_flags[g];
            end
            assign flags[g] = flag_q;
        end else begin : g_absent
            assign flags[g] = 1'b0;
        end
    end

    // R11
    capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> (flags == ($past(cap_flags) & TRAP_IMPL)));
endmodule

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
    import fpx_pkg::*;
#(
    parameter logic [NUM_CLS-1:0] TRAP_IMPL = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_wr,
    input  logic [REG_W-1:0]   sw_wdata,
    output logic [REG_W-1:0]   rd_data,
    input  logic               cap_valid,
    input  logic               cap_allocated,
    input  logic               cap_vector,
    input  logic [NUM_CLS-1:0] cap_raised,
    input  logic [NUM_CLS-1:0] trap_en,
    input  logic               flush_zero,
    input  logic               half_flush,
    input  logic               fp_access,
    output logic               fp_undef
);
    logic               en_q;
    logic               dex, tfv;
    logic [NUM_CLS-1:0] cap_flags, sw_flags, flags;
    logic               unused_wbits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (sw_wr) en_q <= sw_wdata[EN_BIT];
    end

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_wsel
        assign sw_flags[g] = sw_wdata[cls_pos(g)];
    end
    assign unused_wbits = ^{sw_wdata[31], sw_wdata[28:26], sw_wdata[25:8], sw_wdata[6:5]};

    fpx_cause u_cause (
        .cap_allocated (cap_allocated),
        .cap_vector    (cap_vector),
        .cap_raised    (cap_raised),
        .trap_en       (trap_en),
        .flush_zero    (flush_zero),
        .half_flush    (half_flush),
        .cap_flags     (cap_flags)
    );

    fpx_exc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_valid     (cap_valid),
        .cap_allocated (cap_allocated),
        .cap_vector    (cap_vector),
        .sw_wr         (sw_wr),
        .sw_dex        (sw_wdata[DEX_BIT]),
        .dex           (dex),
        .tfv           (tfv)
    );

    fpx_flag_bank #(.TRAP_IMPL(TRAP_IMPL)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_valid (cap_valid),
        .cap_flags (cap_flags),
        .sw_wr     (sw_wr),
        .sw_flags  (sw_flags),
        .flags     (flags)
    );

    always_comb begin
        rd_data          = FIXED_ONES;
        rd_data[EN_BIT]  = en_q;
        rd_data[DEX_BIT] = dex;
        rd_data[TFV_BIT] = tfv;
        for (int i = 0; i < NUM_CLS; i++) begin
            rd_data[cls_pos(i)] = flags[i];
        end
    end

    assign fp_undef = fp_access && !en_q;

    // R3
    enable_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (rd_data[EN_BIT] == $past(sw_wdata[EN_BIT])));
    // R3
    undef_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp_undef |-> fp_access);
    // R4
    trap_cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_allocated && !cap_vector) |=> (rd_data[DEX_BIT] && rd_data[TFV_BIT]));
    // R5
    vector_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_allocated && cap_vector) |=> (rd_data[DEX_BIT] && !rd_data[TFV_BIT]));
    // R7
    denormal_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !flush_zero) |=> !rd_data[7]);
endmodule

// File: tb/test_fpx_ctrl_reg.sv
module test_fpx_ctrl_reg;
    localparam logic [5:0] PART_IMPL = 6'b010101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        cap_valid = 1'b0, cap_allocated = 1'b0, cap_vector = 1'b0;
    logic [5:0]  cap_raised = '0, trap_en = '0;
    logic        flush_zero = 1'b0, half_flush = 1'b0, fp_access = 1'b0;
    logic [31:0] rd_full, rd_part;
    logic        undef_full, undef_part;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fpx_ctrl_reg i_fpx_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .rd_data(rd_full),
        .cap_valid(cap_valid), .cap_allocated(cap_allocated), .cap_vector(cap_vector),
        .cap_raised(cap_raised), .trap_en(trap_en), .flush_zero(flush_zero),
        .half_flush(half_flush), .fp_access(fp_access), .fp_undef(undef_full)
    );

    fpx_ctrl_reg #(.TRAP_IMPL(PART_IMPL)) i_fpx_ctrl_reg_part (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .rd_data(rd_part),
        .cap_valid(cap_valid), .cap_allocated(cap_allocated), .cap_vector(cap_vector),
        .cap_raised(cap_raised), .trap_en(trap_en), .flush_zero(flush_zero),
        .half_flush(half_flush), .fp_access(fp_access), .fp_undef(undef_part)
    );

    function automatic logic [31:0] pack(input logic en, input logic dex, input logic tfv,
                                         input logic [5:0] fl);
        logic [31:0] v;
        v = 32'h0000_0700;
        v[30] = en; v[29] = dex; v[26] = tfv; v[7] = fl[5]; v[4:0] = fl[4:0];
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sw_write(input logic [31:0] d);
        sw_wr = 1'b1; sw_wdata = d;
        step();
        sw_wr = 1'b0; sw_wdata = '0;
    endtask

    task automatic capture(input logic alloc, input logic vec, input logic [5:0] rs,
                           input logic [5:0] te, input logic fz, input logic hf);
        cap_valid = 1'b1; cap_allocated = alloc; cap_vector = vec;
        cap_raised = rs; trap_en = te; flush_zero = fz; half_flush = hf;
        step();
        cap_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] exp6;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 full", rd_full, 32'h0000_0700);
        chk("R1 part", rd_part, 32'h0000_0700);
        rst_n = 1'b1;
        step();

        // R3 undefined access while disabled
        fp_access = 1'b1;
        #1;
        chk("R3 undef when off", {31'b0, undef_full}, 32'd1);
        fp_access = 1'b0;

        // R2 R8 R9 R10: all-ones write
        sw_write(32'hFFFF_FFFF);
        chk("R2 R8 R9 full", rd_full, pack(1'b1, 1'b0, 1'b0, 6'h3F));
        chk("R10 part", rd_part, pack(1'b1, 1'b0, 1'b0, PART_IMPL));
        fp_access = 1'b1;
        #1;
        chk("R3 no undef when on", {31'b0, undef_full}, 32'd0);
        fp_access = 1'b0;
        sw_write(32'h0000_0000);
        chk("R3 enable cleared", rd_full, pack(1'b0, 1'b0, 1'b0, 6'h0));
        sw_write(32'h4000_0000);

        // R4 R7 R10 sweep of causes
        for (int f = 0; f < 4; f++) begin
            for (int rs = 0; rs < 64; rs++) begin
                for (int te = 0; te < 64; te++) begin
                    capture(1'b1, 1'b0, 6'(rs), 6'(te), f[0], f[1]);
                    exp6 = 6'(rs) & 6'(te);
                    if (!(f[0] && !f[1])) exp6[5] = 1'b0;
                    chk("R4 R7 full", rd_full, pack(1'b1, 1'b1, 1'b1, exp6));
                    chk("R10 R7 part", rd_part, pack(1'b1, 1'b1, 1'b1, exp6 & PART_IMPL));
                end
            end
        end

        // R8 software cannot clear bit 26; R9 writing bit 29 as 1 keeps it
        capture(1'b1, 1'b0, 6'h3F, 6'h3F, 1'b1, 1'b0);
        sw_write(32'h6000_0000);
        chk("R8 R9 keep", rd_full, pack(1'b1, 1'b1, 1'b1, 6'h00));
        // R9 clear bit 29, flags written
        sw_write(32'h4000_0085);
        chk("R9 clear dex", rd_full, pack(1'b1, 1'b0, 1'b1, 6'b100101));
        chk("R9 R10 part", rd_part, pack(1'b1, 1'b0, 1'b1, 6'b100101 & PART_IMPL));

        // R5 vector cause
        capture(1'b1, 1'b1, 6'h3F, 6'h3F, 1'b1, 1'b0);
        chk("R5 vector", rd_full, pack(1'b1, 1'b1, 1'b0, 6'h00));
        // R8 software cannot set bit 26
        sw_write(32'h6400_0000);
        chk("R8 set ignored", rd_full, pack(1'b1, 1'b1, 1'b0, 6'h00));

        // R6 unallocated encoding
        capture(1'b1, 1'b0, 6'h3F, 6'h3F, 1'b1, 1'b0);
        capture(1'b0, 1'b0, 6'h3F, 6'h3F, 1'b1, 1'b0);
        chk("R6 unallocated", rd_full, pack(1'b1, 1'b0, 1'b0, 6'h00));

        // R11 capture and write together
        sw_wr = 1'b1; sw_wdata = 32'h0000_0000;
        capture(1'b1, 1'b0, 6'b101010, 6'h3F, 1'b1, 1'b0);
        sw_wr = 1'b0;
        chk("R11 collide full", rd_full, pack(1'b0, 1'b1, 1'b1, 6'b101010));
        chk("R11 collide part", rd_part, pack(1'b0, 1'b1, 1'b1, 6'b101010 & PART_IMPL));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule